// File: doc/BRIEF.md
# Byte-Granular Instruction Prefetch Buffer

This block sits between a memory read port and an instruction decoder. It fetches aligned 32-bit words from consecutive addresses ahead of demand and keeps them as a ring of single bytes. The decoder sees the four oldest bytes and a count of how many of them are valid. Each cycle it removes between zero and four bytes. Because words go in whole and bytes come out in any amount, one fetched word can hold the end of one instruction and the start of the next.

A redirect input, for example one raised on a taken branch, clears the buffer. It discards any responses still due for requests made before the redirect. Fetching then restarts from the aligned word that holds the new byte address, and the bytes of that first word that sit below the target are dropped. After reset the block stays idle until the first redirect supplies a start address.

The memory side uses a request/grant handshake. Responses come back in order, one per cycle, at least one cycle after the grant.

Top module: `ifq_prefetch`

## Requirements
- R1: After reset, and until the first redirect, `mem_req` stays low and `dec_count` is 0.
- R2: The first request after a redirect carries the target address with bits [1:0] cleared. Each granted request raises the next request address by 4.
- R3: `mem_req` is high exactly when all of the following hold:
  - a start address has been loaded;
  - no redirect is present this cycle;
  - fewer than DEPTH/4 requests are outstanding, counting discarded ones;
  - stored bytes + 4 × live outstanding requests + 4 ≤ DEPTH.
- R4: In `mem_rdata`, byte lane k (bits 8k+7:8k) holds address word_base+k. In `dec_bytes`, lane i holds the byte at stream position oldest+i. Bytes leave in ascending address order.
- R5: `dec_count` equals the number of stored bytes, limited to 4.
- R6: A take of n (0 to 4, at most `dec_count`) removes the n oldest bytes. When a response is written and bytes are taken in the same cycle, both apply in that cycle.
- R7: A redirect empties the buffer by the next cycle and ignores `dec_take` in that cycle. Responses to requests granted before the redirect are discarded, including a response that arrives in the redirect cycle itself.
- R8: From the first kept response after a redirect, only the bytes at or above the target's offset within the word are stored. The oldest byte then is the byte at the target address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| redirect | input | 1 | Flush and restart fetching |
| redirect_addr | input | AW | Byte address to restart from |
| mem_req | output | 1 | Fetch request |
| mem_addr | output | AW | Word-aligned fetch address |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Response data present |
| mem_rdata | input | 32 | Response word, lowest address in bits 7:0 |
| dec_bytes | output | 32 | Four oldest bytes, oldest in bits 7:0 |
| dec_count | output | 3 | Valid bytes in dec_bytes (0..4) |
| dec_take | input | 3 | Bytes consumed this cycle |

## Verification
The bench builds the block at its default DEPTH of 16 bytes, where only four words of space exist. At that size the room rule and the cap on outstanding requests both bind often.

It sweeps three response latencies, three grant patterns, all four target offsets and three consume policies. One consume policy stalls the decoder long enough to fill the buffer completely. Each run redirects in the middle of the stream while responses are still in flight, so discarded responses, responses that arrive in the redirect cycle and every leading-byte drop amount are all reached.

// File: rtl/ifq_prefetch.sv
`timescale 1ns/1ps
module ifq_prefetch #(
  parameter int AW    = 32,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          redirect,
  input  logic [AW-1:0] redirect_addr,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_gnt,
  input  logic          mem_rvalid,
  input  logic [31:0]   mem_rdata,
  output logic [31:0]   dec_bytes,
  output logic [2:0]    dec_count,
  input  logic [2:0]    dec_take
);
  localparam int PW   = $clog2(DEPTH);
  localparam int CW   = $clog2(DEPTH + 1);
  localparam int MAXO = DEPTH / 4;
  localparam int OW   = $clog2(MAXO + 1);
  localparam int NW   = CW + OW + 3;

  logic [7:0]    ring [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] cnt;
  logic [OW-1:0] pend, stale;
  logic [1:0]    skip;
  logic          run;
  logic [AW-1:0] faddr;

  logic [OW-1:0] live;
  logic [NW-1:0] need;
  logic          accept, keep_rsp;
  logic [2:0]    wr_n, take_n;
  logic [31:0]   shifted;

  assign live     = pend - stale;
  assign need     = NW'(cnt) + (NW'(live) << 2) + NW'(4);
  assign mem_req  = run & ~redirect & (pend < OW'(MAXO)) & (need <= NW'(DEPTH));
  assign mem_addr = faddr;
  assign accept   = mem_req & mem_gnt;
  assign keep_rsp = mem_rvalid & (stale == '0) & ~redirect;
  assign wr_n     = keep_rsp ? 3'd4 - {1'b0, skip} : 3'd0;
  assign take_n   = redirect ? 3'd0 : dec_take;
  assign shifted  = mem_rdata >> {skip, 3'b000};
  assign dec_count = (cnt >= CW'(4)) ? 3'd4 : cnt[2:0];

  for (genvar i = 0; i < 4; i++) begin : g_view
    assign dec_bytes[8*i +: 8] = ring[rd_ptr + PW'(i)];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
      pend   <= '0;
      stale  <= '0;
      skip   <= '0;
      run    <= 1'b0;
      faddr  <= '0;
    end else begin
      pend <= pend + OW'(accept) - OW'(mem_rvalid);
      if (redirect) begin
        run    <= 1'b1;
        faddr  <= {redirect_addr[AW-1:2], 2'b00};
        skip   <= redirect_addr[1:0];
        rd_ptr <= '0;
        wr_ptr <= '0;
        cnt    <= '0;
        stale  <= pend - OW'(mem_rvalid);
      end else begin
        if (accept) faddr <= faddr + AW'(4);
        if (mem_rvalid && stale != '0) stale <= stale - OW'(1);
        if (keep_rsp) skip <= 2'b00;
        rd_ptr <= rd_ptr + PW'(take_n);
        wr_ptr <= wr_ptr + PW'(wr_n);
        cnt    <= cnt + CW'(wr_n) - CW'(take_n);
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < 4; k++)
      if (keep_rsp && 3'(k) < wr_n)
        ring[wr_ptr + PW'(k)] <= shifted[8*k +: 8];
  end

  a_r6_take_within_count: assert property (@(posedge clk) disable iff (!rst_n)
    !redirect |-> dec_take <= dec_count);
  a_r3_no_overfill: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  a_r3_rsp_was_requested: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rvalid |-> pend != '0);
  a_r2_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00);
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> mem_addr == $past(mem_addr) + AW'(4));
  a_r7_empty_after_flush: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> dec_count == 3'd0);
  a_r1_idle_until_load: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !mem_req);
  a_r7_stale_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    stale <= pend);
endmodule

// File: tb/sim_ifq_prefetch.sv
`timescale 1ns/1ps
module sim_ifq_prefetch;
  localparam int AW = 32;
  localparam int DEPTH = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic redirect = 1'b0;
  logic [AW-1:0] redirect_addr = '0;
  logic mem_req, mem_gnt = 1'b0, mem_rvalid = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_rdata = '0, dec_bytes;
  logic [2:0] dec_count, dec_take = '0;

  always #5 clk = ~clk;

  ifq_prefetch #(.AW(AW), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .redirect(redirect), .redirect_addr(redirect_addr),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .dec_bytes(dec_bytes), .dec_count(dec_count), .dec_take(dec_take));

  int errs = 0, checks = 0, cyc = 0;
  int qa[64], qd[64], qe[64];
  int qh = 0, qt = 0, epoch = 0, occ = 0, live_out = 0;
  int exp_addr = 0, next_req = 0, skip = 0, lat = 1, gmode = 0;
  bit started = 0, first = 0, r8_due = 0, r7_due = 0, r6_due = 0, flushed = 0;

  function automatic logic [7:0] bat(input int a);
    return 8'((a * 29) + (a >>> 5) + 7);
  endfunction

  function automatic int min4(input int v);
    return (v > 4) ? 4 : v;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  task automatic step(input bit do_flush, input int tgt, input int pol);
    int take, avail, wbytes;
    bit exp_req;
    avail = min4(occ);
    if (!started) chk(mem_req == 0 && dec_count == 0, "R1", int'(mem_req), 0);
    chk(int'(dec_count) == avail,
        r7_due ? "R7" : (r6_due ? "R6" : "R5"), int'(dec_count), avail);
    for (int i = 0; i < 4; i++)
      if (i < avail)
        chk(dec_bytes[8*i +: 8] == bat(exp_addr + i), (r8_due && i == 0) ? "R8" : "R4",
            int'(dec_bytes[8*i +: 8]), int'(bat(exp_addr + i)));
    r8_due = 0; r7_due = 0; r6_due = 0;
    take = 0;
    if (!do_flush) begin
      case (pol)
        0: take = avail;
        1: take = (cyc % 5 < avail) ? cyc % 5 : avail;
        default: take = (cyc % 10 < 6) ? 0 : avail;
      endcase
    end
    redirect = do_flush;
    redirect_addr = AW'(tgt);
    dec_take = 3'(take);
    mem_gnt = (gmode == 0) ? 1'b1 : (gmode == 1) ? 1'(cyc % 2) : 1'(cyc % 3 != 0);
    mem_rvalid = 1'b0;
    if (qh != qt && qd[qh % 64] <= cyc) begin
      mem_rvalid = 1'b1;
      mem_rdata = {bat(qa[qh%64]+3), bat(qa[qh%64]+2), bat(qa[qh%64]+1), bat(qa[qh%64])};
    end
    #1;
    exp_req = started && !do_flush && (qt - qh) < DEPTH/4 && occ + 4*live_out + 4 <= DEPTH;
    chk(mem_req == exp_req, "R3", int'(mem_req), int'(exp_req));
    if (mem_req) chk(mem_addr == AW'(next_req), "R2", int'(mem_addr), next_req);
    wbytes = 0;
    if (mem_rvalid) begin
      if (qe[qh % 64] == epoch) begin
        live_out--;
        if (!do_flush) begin
          wbytes = first ? 4 - skip : 4;
          if (first) r8_due = 1;
          first = 0;
        end
      end else r7_due = 1;
      qh++;
    end
    if (mem_req && mem_gnt) begin
      qa[qt % 64] = next_req; qd[qt % 64] = cyc + lat; qe[qt % 64] = epoch;
      qt++; live_out++; next_req += 4;
    end
    if (wbytes > 0 && take > 0) r6_due = 1;
    occ = occ + wbytes - take;
    exp_addr += take;
    if (do_flush) begin
      epoch++; live_out = 0; occ = 0; exp_addr = tgt; next_req = tgt & ~3;
      first = 1; skip = tgt & 3; started = 1; r7_due = 1;
    end
    @(posedge clk);
    @(negedge clk);
    cyc++;
  endtask

  initial begin
    #1_000_000;
    checks++; errs++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int run_id;
    run_id = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 6; i++) step(0, 0, 0);  // R1 idle window
    for (int l = 1; l <= 3; l++)
      for (int g = 0; g < 3; g++)
        for (int off = 0; off < 4; off++)
          for (int p = 0; p < 3; p++) begin
            lat = l; gmode = g;
            run_id++;
            step(1, run_id * 256 + off, p);
            for (int c = 0; c < 24; c++) step(0, 0, p);
            step(1, run_id * 256 + 131 + ((off + p) % 4), p);
            for (int c = 0; c < 30; c++) step(0, 0, p);
          end
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule